// File: doc/BRIEF.md
# Windowed Watchdog Timer Controller

This block supervises software by counting pulses of a slow (nominally 1 kHz) tick input. Once enabled, software must issue a refresh before a programmable number of ticks passes. If it does not, the block raises a single-cycle reset request. In window mode the timeout is split into two parts. First comes a closed window, during which a refresh is treated as a fault. An open window follows, during which a refresh is accepted and restarts the count.

Two byte-wide registers hold the configuration. The control register holds the enable bit and the open-period code. The window register holds the window enable bit and the closed-period code. A write changes a register only when that write also sets the register's own commit bit. A lock input freezes both period codes and the window enable. At reset the period codes load from fuse input ports. Each period code `c` selects `8 * 2^min(c,10)` ticks, which is 8 ticks up to 8192 ticks.

Top module: `wdt_win_ctrl`

## Requirements
- R1: After reset, enable and window enable are 0, the open and closed period codes equal `fuse_open_code` and `fuse_closed_code`, and `reset_req` is 0.
- R2: A write with `wr_sel`=0 changes the control register only if `wr_data[0]` is 1. In that case bit 1 becomes the enable bit and bits 5:2 become the open-period code. Otherwise the write is ignored.
- R3: A write with `wr_sel`=1 changes the window register only if `wr_data[0]` is 1. In that case bit 1 becomes the window enable and bits 5:2 become the closed-period code. Otherwise the write is ignored.
- R4: While `lock` is 1, writes leave both period codes and the window enable unchanged. The enable bit stays writable.
- R5: Both readback buses show bits 7:6 and bit 0 as zero, whatever was written to them.
- R6: With window mode off and the block enabled, the tick that completes `8*2^min(code,10)` ticks since the last restart raises `reset_req` in the following clock cycle. The count then restarts.
- R7: A refresh while enabled restarts the tick count from zero.
- R8: With window mode on, a refresh that arrives while fewer than the closed-period ticks have been counted raises `reset_req` in the following cycle and restarts the count. A refresh at or after that count is accepted without a pulse.
- R9: With window mode on, the timeout occurs after the closed-period ticks plus the open-period ticks.
- R10: With window mode off, the closed-period code has no effect: early refreshes cause no pulse, and the timeout uses the open period only.
- R11: Period codes 11 to 15 select the 8192-tick maximum.
- R12: While disabled, ticks and refreshes produce no `reset_req`.
- R13: Every `reset_req` pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per slow-oscillator period |
| refresh | input | 1 | Software refresh strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the window register |
| wr_data | input | 8 | Write data |
| lock | input | 1 | Freezes period codes and window enable |
| fuse_open_code | input | 4 | Reset value of the open-period code |
| fuse_closed_code | input | 4 | Reset value of the closed-period code |
| rd_ctrl | output | 8 | Control register readback |
| rd_win | output | 8 | Window register readback |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification
The hardest condition to reach from the ports is a refresh that lands exactly on the edge of the closed window. One case is a refresh after `closed-1` ticks, which must fault. The other is a refresh after exactly `closed` ticks, which must be accepted. The stimulus restarts the count with a known event and then issues a counted number of ticks before refreshing. The bench therefore always knows the internal count. The saturated code 15 is also exercised by a full run of 8192 ticks.

// File: rtl/wdt_pkg.sv
// Package: shared constants and the period-decode function for the windowed watchdog.
// Assumes period codes are CODE_W bits and saturate at MAX_CODE.
package wdt_pkg;
    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 10;
    localparam int BASE_SHIFT = 3;
    // Room for closed + open at their maxima.
    localparam int CNT_W      = BASE_SHIFT + MAX_CODE + 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  count_t;

    // Map a period code to its tick count, saturating codes above MAX_CODE.
    function automatic count_t period_ticks(input code_t code);
        int unsigned sh;
        sh = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        return count_t'(1) << (BASE_SHIFT + sh);
    endfunction
endpackage

// File: rtl/wdt_regs.sv
// Module: configuration registers with commit bit and lock.
// A write commits only when bit 0 of the data is set. Lock freezes period codes
// and the window enable. Reserved bits and commit bits read back as zero.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        lock,
    input  code_t       fuse_open_code,
    input  code_t       fuse_closed_code,
    output logic        enable,
    output logic        win_en,
    output code_t       open_code,
    output code_t       closed_code,
    output logic [7:0]  rd_ctrl,
    output logic [7:0]  rd_win
);
    localparam int COMMIT_BIT = 0;
    localparam int EN_BIT     = 1;
    localparam int CODE_LSB   = 2;

    logic commit;
    code_t wr_code;

    assign commit  = wr_en && wr_data[COMMIT_BIT];
    assign wr_code = wr_data[CODE_LSB +: CODE_W];

    // Control register: enable always writable on commit, open code only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            open_code <= fuse_open_code;
        end else if (commit && !wr_sel) begin
            enable <= wr_data[EN_BIT];
            if (!lock) open_code <= wr_code;
        end
    end

    // Window register: both fields writable only on commit while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en      <= 1'b0;
            closed_code <= fuse_closed_code;
        end else if (commit && wr_sel && !lock) begin
            win_en      <= wr_data[EN_BIT];
            closed_code <= wr_code;
        end
    end

    // Readback packing: reserved and commit positions read as zero.
    always_comb begin
        rd_ctrl = '0;
        rd_ctrl[EN_BIT] = enable;
        rd_ctrl[CODE_LSB +: CODE_W] = open_code;
        rd_win = '0;
        rd_win[EN_BIT] = win_en;
        rd_win[CODE_LSB +: CODE_W] = closed_code;
    end

    assert_lock_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(open_code) && $stable(closed_code) && $stable(win_en)));

    assert_ctrl_nocommit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !wr_data[COMMIT_BIT]) |=> ($stable(enable) && $stable(open_code)));

    assert_win_nocommit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !wr_data[COMMIT_BIT]) |=> ($stable(win_en) && $stable(closed_code)));
endmodule

// File: rtl/wdt_core.sv
// Module: tick counter, closed-window fault check and timeout detection.
// Assumes tick is a one-cycle pulse. A refresh takes priority over a tick in the same cycle.
// The count is held at zero while disabled.
module wdt_core
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   refresh,
    input  logic   enable,
    input  logic   win_en,
    input  code_t  open_code,
    input  code_t  closed_code,
    output logic   reset_req
);
    count_t cnt;
    count_t closed_len;
    count_t limit;
    logic   early;

    // Window sizes from the current codes; the closed window vanishes outside window mode.
    always_comb begin
        closed_len = win_en ? period_ticks(closed_code) : '0;
        limit      = closed_len + period_ticks(open_code);
        early      = cnt < closed_len;
    end

    // Counter and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (!enable) begin
                cnt <= '0;
            end else if (refresh) begin
                cnt <= '0;
                if (early) reset_req <= 1'b1;
            end else if (tick) begin
                if (cnt >= limit - count_t'(1)) begin
                    cnt       <= '0;
                    reset_req <= 1'b1;
                end else begin
                    cnt <= cnt + count_t'(1);
                end
            end
        end
    end

    assert_quiet_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !reset_req);

    assert_refresh_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && refresh) |=> (cnt == '0));

    assert_early_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && win_en && refresh && early) |=> reset_req);

    assert_no_refresh_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !win_en && refresh) |=> !reset_req);
endmodule

// File: rtl/wdt_win_ctrl.sv
// Module: top of the windowed watchdog. Joins the register file to the counter core.
// Assumes tick is synchronous to clk and lasts one cycle.
module wdt_win_ctrl
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        refresh,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        lock,
    input  logic [3:0]  fuse_open_code,
    input  logic [3:0]  fuse_closed_code,
    output logic [7:0]  rd_ctrl,
    output logic [7:0]  rd_win,
    output logic        reset_req
);
    logic  enable;
    logic  win_en;
    code_t open_code;
    code_t closed_code;

    wdt_regs u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_sel           (wr_sel),
        .wr_data          (wr_data),
        .lock             (lock),
        .fuse_open_code   (fuse_open_code),
        .fuse_closed_code (fuse_closed_code),
        .enable           (enable),
        .win_en           (win_en),
        .open_code        (open_code),
        .closed_code      (closed_code),
        .rd_ctrl          (rd_ctrl),
        .rd_win           (rd_win)
    );

    wdt_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .refresh     (refresh),
        .enable      (enable),
        .win_en      (win_en),
        .open_code   (open_code),
        .closed_code (closed_code),
        .reset_req   (reset_req)
    );

    assert_pulse_needs_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(enable));
endmodule

// File: tb/wdt_win_ctrl_tb_top.sv
// Bench: the driver pushes the expected tick index of each reset request into a queue.
// The monitor pops and compares as pulses appear.
module wdt_win_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       refresh = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       lock = 1'b0;
    logic [3:0] fuse_open_code = 4'd1;
    logic [3:0] fuse_closed_code = 4'd2;
    logic [7:0] rd_ctrl;
    logic [7:0] rd_win;
    logic       reset_req;

    int checks = 0;
    int errors = 0;
    int tick_no = 0;
    int pulses = 0;
    int exp_q[$];
    logic prev_req = 1'b0;

    always #5 clk = ~clk;

    wdt_win_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .refresh(refresh),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .lock(lock),
        .fuse_open_code(fuse_open_code), .fuse_closed_code(fuse_closed_code),
        .rd_ctrl(rd_ctrl), .rd_win(rd_win), .reset_req(reset_req)
    );

    function automatic int per(input int code);
        return 8 << ((code > 10) ? 10 : code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(posedge clk) tick_no++;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic do_refresh();
        @(negedge clk) refresh = 1'b1;
        @(negedge clk) refresh = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        check({req, " queue drained"}, exp_q.size(), 0);
    endtask

    // Monitor: compare each pulse against the queue and check pulse width.
    always @(posedge clk) begin
        #2;
        if (rst_n && reset_req) begin
            pulses++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected pulse at tick %0d expected none", tick_no);
            end else begin
                check("R6/R8/R9 pulse tick index", tick_no, exp_q.pop_front());
            end
            if (prev_req) check("R13 pulse width", 2, 1);
        end
        prev_req = reset_req;
    end

    // Watchdog on the run itself.
    initial begin
        #1_900_000;
        checks++; errors++;
        $display("FAIL watchdog run hung actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_ctrl", rd_ctrl, 8'h04);
        check("R1 rd_win", rd_win, 8'h08);
        check("R1 reset_req", reset_req, 0);

        // R2 / R3 writes without commit bit
        wr(1'b0, 8'h3E);
        check("R2 ctrl ignored", rd_ctrl, 8'h04);
        wr(1'b1, 8'h02);
        check("R3 win ignored", rd_win, 8'h08);

        // R5 reserved and commit bits read zero
        wr(1'b1, 8'hCF);
        check("R5 win readback", rd_win, 8'h0E);
        wr(1'b1, 8'h01);
        check("R3 win commit", rd_win, 8'h00);

        // R12 disabled: ticks and refresh give nothing
        ticks(20);
        do_refresh();
        drain("R12");
        check("R12 no pulses", pulses, 0);

        // R6 normal timeout, code 0 then code 2
        wr(1'b0, 8'h03);
        check("R2 ctrl commit", rd_ctrl, 8'h02);
        exp_q.push_back(tick_no + per(0));
        ticks(per(0));
        drain("R6 code0");
        wr(1'b0, 8'h0B);
        exp_q.push_back(tick_no + per(2));
        ticks(per(2));
        drain("R6 code2");

        // R7 refresh restarts count
        wr(1'b0, 8'h03);
        ticks(5);
        do_refresh();
        exp_q.push_back(tick_no + 8);
        ticks(8);
        drain("R7");

        // R10 closed code ignored with window off
        wr(1'b1, 8'h0D);
        ticks(1);
        do_refresh();
        exp_q.push_back(tick_no + 8);
        ticks(8);
        drain("R10");

        // R8 window mode: closed 8, open 8
        wr(1'b1, 8'h03);
        ticks(3);
        exp_q.push_back(tick_no);
        do_refresh();
        drain("R8 early");
        ticks(7);
        exp_q.push_back(tick_no);
        do_refresh();
        drain("R8 boundary closed-1");
        ticks(8);
        do_refresh();
        drain("R8 boundary closed accepted");
        // R9 full timeout at closed+open
        exp_q.push_back(tick_no + 16);
        ticks(16);
        drain("R9");
        check("R13 pulse total", pulses, 7);

        // R4 lock freezes codes and window enable; enable still writes
        lock = 1'b1;
        wr(1'b1, 8'h01);
        check("R4 win frozen", rd_win, 8'h02);
        wr(1'b0, 8'h15);
        check("R4 ctrl code frozen enable written", rd_ctrl, 8'h00);
        lock = 1'b0;

        // R11 saturated code 15
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h3F);
        check("R11 readback", rd_ctrl, 8'h3E);
        exp_q.push_back(tick_no + 8192);
        ticks(8192);
        drain("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule